// File: doc/BRIEF.md
# Execute and Write-Back Stage with GPIO Port

This block is the back half of a small three-stage RV32 integer pipeline. It takes the operands and control that the decode stage has already produced and finishes the instruction. First it picks the second ALU operand, either the second register value or the sign-extended 12-bit immediate. It then runs the ALU and registers everything the write-back stage needs. One clock later it presents a single write to the register file. That write carries the ALU result, the upper immediate placed in bits 31:12, or a sample of the switch inputs.

A CSR-style move instruction does not go through the write-back path. It copies the low bits of the first register value straight into a registered GPIO output, and that output holds until the next such instruction. Fetch, decode, the register array and branch logic sit outside the block. The register file should take the write-port signals as they are, with no further staging.

Top module: `exwb_stage`

## Requirements
- R1: When `ex_use_imm` is 1, ALU operand B is the 12-bit immediate sign-extended to 32 bits. When it is 0, operand B is `ex_rs2_val`. Operand A is always `ex_rs1_val`.
- R2: `ex_alu_op` selects the ALU function: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic, 8 signed less-than (result 1 or 0), 9 unsigned less-than (result 1 or 0).
- R3: The registered copy of `ex_wb_sel` picks `wb_data`: 0 gives the ALU result, 1 gives `{ex_uimm, 12'b0}`, 2 gives `ex_sw_in` zero-extended, and 3 gives zero.
- R4: Every write-back output shows the values captured from the execute-stage inputs at the previous rising clock edge. This covers `wb_rd`, `wb_data`, and the select that chose the data.
- R5: A write to register index 0 never asserts `wb_we`, whatever `ex_reg_we` is.
- R6: On the edge after `ex_gpio_we` is high, `gpio_out` equals the low `GPIO_W` bits of `ex_rs1_val`. Otherwise `gpio_out` keeps its value.
- R7: A synchronous active-high `rst` clears `wb_we`, `wb_rd`, `wb_data` and `gpio_out` to zero at the next rising edge.
- R8: `wb_we` is high in the cycle after `ex_reg_we` was high with a nonzero `ex_rd`, and is low in every other cycle.
- R9: ALU operation codes 10 to 15 give a result of zero.
- R10: All three shifts use only bits 4:0 of operand B as the shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs1_val | input | 32 | First register read value (ALU operand A, GPIO source) |
| ex_rs2_val | input | 32 | Second register read value |
| ex_imm12 | input | 12 | Raw 12-bit immediate, sign-extended inside the block |
| ex_uimm | input | 20 | Upper immediate |
| ex_sw_in | input | GPIO_W | Switch inputs |
| ex_use_imm | input | 1 | Operand B select (1 = immediate) |
| ex_alu_op | input | 4 | ALU operation code |
| ex_wb_sel | input | 2 | Write-back source select |
| ex_reg_we | input | 1 | Register write request |
| ex_gpio_we | input | 1 | GPIO output load request |
| ex_rd | input | 5 | Destination register index |
| wb_we | output | 1 | Register-file write enable |
| wb_rd | output | 5 | Register-file write index |
| wb_data | output | 32 | Register-file write data |
| gpio_out | output | GPIO_W | Registered GPIO output |

## Verification
The bound checker checks the cycle-by-cycle rules on every cycle after reset:
- the one-edge delay of index and enable;
- suppression of writes to register 0;
- loading and holding of the GPIO output;
- the upper-immediate, switch and zero write-back paths.

ALU arithmetic is not covered by the assertions. The same holds for immediate sign extension, the handling of the shift amount and the reset values. These are shown only by the bench's scenarios. The bench runs directed operand corners (negative immediates, shift counts above 31, signed against unsigned comparisons, unused operation codes, a mid-run reset) and a long random stream checked against its reference model.

// File: rtl/exwb_pkg.sv
package exwb_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 12;
    localparam int UIMM_W  = 20;
    localparam int UPAD_W  = XLEN - UIMM_W;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ALU    = 2'd0,
        SRC_UPPER  = 2'd1,
        SRC_SWITCH = 2'd2,
        SRC_NONE   = 2'd3
    } wb_src_e;

    typedef struct packed {
        logic               we;
        logic [IDX_W-1:0]   rd;
        wb_src_e            src;
        logic [XLEN-1:0]    alu;
        logic [UIMM_W-1:0]  upper;
        logic [XLEN-1:0]    sw;
    } exwb_bundle_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/exwb_alu.sv
module exwb_alu
    import exwb_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;

    assign shamt = b[SH_W-1:0];

    always_comb begin
        y = '0;
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << shamt;
            OP_SRL:  y = a >> shamt;
            OP_SRA:  y = $unsigned($signed(a) >>> shamt);
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/exwb_pipe.sv
module exwb_pipe
    import exwb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  exwb_bundle_t  d,
    output exwb_bundle_t  q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/exwb_wbmux.sv
module exwb_wbmux
    import exwb_pkg::*;
(
    input  exwb_bundle_t     q,
    output logic [XLEN-1:0]  data
);
    always_comb begin
        case (q.src)
            SRC_ALU:    data = q.alu;
            SRC_UPPER:  data = {q.upper, {UPAD_W{1'b0}}};
            SRC_SWITCH: data = q.sw;
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/exwb_gpio.sv
module exwb_gpio #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/exwb_stage.sv
module exwb_stage
    import exwb_pkg::*;
#(
    parameter int GPIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        ex_rs1_val,
    input  logic [31:0]        ex_rs2_val,
    input  logic [11:0]        ex_imm12,
    input  logic [19:0]        ex_uimm,
    input  logic [GPIO_W-1:0]  ex_sw_in,
    input  logic               ex_use_imm,
    input  logic [3:0]         ex_alu_op,
    input  logic [1:0]         ex_wb_sel,
    input  logic               ex_reg_we,
    input  logic               ex_gpio_we,
    input  logic [4:0]         ex_rd,
    output logic               wb_we,
    output logic [4:0]         wb_rd,
    output logic [31:0]        wb_data,
    output logic [GPIO_W-1:0]  gpio_out
);
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] sw_ext;
    exwb_bundle_t    ex_bundle;
    exwb_bundle_t    wb_bundle;

    // operand B selection
    always_comb begin
        if (ex_use_imm) opnd_b = sext_imm(ex_imm12);
        else            opnd_b = ex_rs2_val;
    end

    always_comb begin
        sw_ext = '0;
        sw_ext[GPIO_W-1:0] = ex_sw_in;
    end

    exwb_alu #(.W(XLEN)) u_alu (
        .op (alu_op_e'(ex_alu_op)),
        .a  (ex_rs1_val),
        .b  (opnd_b),
        .y  (alu_y)
    );

    always_comb begin
        ex_bundle.we    = ex_reg_we && (ex_rd != '0);
        ex_bundle.rd    = ex_rd;
        ex_bundle.src   = wb_src_e'(ex_wb_sel);
        ex_bundle.alu   = alu_y;
        ex_bundle.upper = ex_uimm;
        ex_bundle.sw    = sw_ext;
    end

    exwb_pipe u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (ex_bundle),
        .q   (wb_bundle)
    );

    exwb_wbmux u_wbmux (
        .q    (wb_bundle),
        .data (wb_data)
    );

    assign wb_we = wb_bundle.we;
    assign wb_rd = wb_bundle.rd;

    exwb_gpio #(.W(GPIO_W)) u_gpio (
        .clk  (clk),
        .rst  (rst),
        .load (ex_gpio_we),
        .d    (ex_rs1_val[GPIO_W-1:0]),
        .q    (gpio_out)
    );
endmodule

// File: rtl/exwb_checker.sv
module exwb_checker #(
    parameter int GPIO_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [31:0]        ex_rs1_val,
    input logic [19:0]        ex_uimm,
    input logic [GPIO_W-1:0]  ex_sw_in,
    input logic [1:0]         ex_wb_sel,
    input logic               ex_reg_we,
    input logic               ex_gpio_we,
    input logic [4:0]         ex_rd,
    input logic               wb_we,
    input logic [4:0]         wb_rd,
    input logic [31:0]        wb_data,
    input logic [GPIO_W-1:0]  gpio_out
);
    logic [31:0] sw_wide;
    always_comb begin
        sw_wide = '0;
        sw_wide[GPIO_W-1:0] = ex_sw_in;
    end

    AST_RD_DELAY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wb_rd == $past(ex_rd)); // R4

    AST_X0_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        (ex_rd == 5'd0) |=> !wb_we); // R5

    AST_WE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (ex_reg_we && ex_rd != 5'd0) |=> wb_we); // R8

    AST_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ex_reg_we |=> !wb_we); // R8

    AST_GPIO_LOAD: assert property (@(posedge clk) disable iff (rst)
        ex_gpio_we |=> gpio_out == $past(ex_rs1_val[GPIO_W-1:0])); // R6

    AST_GPIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ex_gpio_we |=> $stable(gpio_out)); // R6

    AST_WB_UPPER: assert property (@(posedge clk) disable iff (rst)
        (ex_wb_sel == 2'd1) |=> wb_data == {$past(ex_uimm), 12'b0}); // R3

    AST_WB_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (ex_wb_sel == 2'd2) |=> wb_data == $past(sw_wide)); // R3

    AST_WB_NONE: assert property (@(posedge clk) disable iff (rst)
        (ex_wb_sel == 2'd3) |=> wb_data == 32'd0); // R3
endmodule

bind exwb_stage exwb_checker #(.GPIO_W(GPIO_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ex_rs1_val (ex_rs1_val),
    .ex_uimm    (ex_uimm),
    .ex_sw_in   (ex_sw_in),
    .ex_wb_sel  (ex_wb_sel),
    .ex_reg_we  (ex_reg_we),
    .ex_gpio_we (ex_gpio_we),
    .ex_rd      (ex_rd),
    .wb_we      (wb_we),
    .wb_rd      (wb_rd),
    .wb_data    (wb_data),
    .gpio_out   (gpio_out)
);

// File: tb/sim_exwb_stage.sv
`timescale 1ns/1ps
module sim_exwb_stage;
    localparam int GW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   rs1 = '0, rs2 = '0;
    logic [11:0]   imm = '0;
    logic [19:0]   up = '0;
    logic [GW-1:0] sw = '0;
    logic          use_imm = 1'b0;
    logic [3:0]    op = '0;
    logic [1:0]    sel = '0;
    logic          rwe = 1'b0, gwe = 1'b0;
    logic [4:0]    rd = '0;
    logic          wb_we;
    logic [4:0]    wb_rd;
    logic [31:0]   wb_data;
    logic [GW-1:0] gpio_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exwb_stage #(.GPIO_W(GW)) u0 (
        .clk(clk), .rst(rst), .ex_rs1_val(rs1), .ex_rs2_val(rs2),
        .ex_imm12(imm), .ex_uimm(up), .ex_sw_in(sw), .ex_use_imm(use_imm),
        .ex_alu_op(op), .ex_wb_sel(sel), .ex_reg_we(rwe), .ex_gpio_we(gwe),
        .ex_rd(rd), .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .gpio_out(gpio_out)
    );

    // behavioural reference
    function automatic logic [31:0] ref_alu(input int code, input logic [31:0] a, input logic [31:0] b);
        int s;
        s = int'(b % 32);
        case (code)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << s;
            6: return a >> s;
            7: return $unsigned($signed(a) >>> s);
            8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            9: return (a < b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    logic          m_we = 0;
    logic [4:0]    m_rd = 0;
    logic [31:0]   m_data = 0;
    logic [GW-1:0] m_gpio = 0;
    string         m_tag = "R7";

    always @(posedge clk) begin
        logic [31:0] b;
        if (rst) begin
            m_we <= 0; m_rd <= 0; m_data <= 0; m_gpio <= 0; m_tag <= "R7";
        end else begin
            b = use_imm ? {{20{imm[11]}}, imm} : rs2;
            m_we <= rwe && (rd != 0);
            m_rd <= rd;
            case (sel)
                2'd0: begin
                    m_data <= ref_alu(int'(op), rs1, b);
                    m_tag <= (op > 9) ? "R9" : (use_imm ? "R1" : "R2");
                end
                2'd1: begin m_data <= up * 32'd4096; m_tag <= "R3"; end
                2'd2: begin m_data <= 32'(sw); m_tag <= "R3"; end
                default: begin m_data <= 0; m_tag <= "R3"; end
            endcase
            if (gwe) m_gpio <= rs1[GW-1:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R8", 32'(wb_we), 32'(m_we));
            chk("R4", 32'(wb_rd), 32'(m_rd));
            chk(m_tag, wb_data, m_data);
            chk("R6", 32'(gpio_out), 32'(m_gpio));
        end
    end

    task automatic drive(input logic [31:0] a, input logic [31:0] b2, input logic [11:0] i12,
                         input logic ui, input logic [3:0] code, input logic [1:0] s,
                         input logic we, input logic [4:0] dst);
        @(negedge clk); #1;
        rs1 = a; rs2 = b2; imm = i12; use_imm = ui; op = code; sel = s;
        rwe = we; rd = dst; gwe = 0;
    endtask

    task automatic expect_out(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
        chk(tag, act_sel, exp);
    endtask

    task automatic settle;
        @(negedge clk); #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        expect_out("R7", {wb_we, wb_rd, gpio_out}, 32'd0);
        expect_out("R7", wb_data, 32'd0);
        rst = 0;

        drive(32'd5, 32'd7, 12'd0, 0, 4'd1, 2'd0, 1, 5'd3); settle;
        expect_out("R2", wb_data, 32'hFFFF_FFFE);
        drive(32'd10, 32'd0, 12'hFFF, 1, 4'd0, 2'd0, 1, 5'd4); settle;
        expect_out("R1", wb_data, 32'd9);
        drive(32'h8000_0000, 32'd0, 12'd36, 1, 4'd7, 2'd0, 1, 5'd4); settle;
        expect_out("R10", wb_data, 32'hF800_0000);
        drive(32'h8000_0000, 32'd33, 12'd0, 0, 4'd6, 2'd0, 1, 5'd4); settle;
        expect_out("R10", wb_data, 32'h4000_0000);
        drive(32'd1, 32'd31, 12'd0, 0, 4'd5, 2'd0, 1, 5'd4); settle;
        expect_out("R2", wb_data, 32'h8000_0000);
        drive(32'hFFFF_FFFF, 32'd1, 12'd0, 0, 4'd8, 2'd0, 1, 5'd4); settle;
        expect_out("R2", wb_data, 32'd1);
        drive(32'hFFFF_FFFF, 32'd1, 12'd0, 0, 4'd9, 2'd0, 1, 5'd4); settle;
        expect_out("R2", wb_data, 32'd0);
        drive(32'hF0F0_1234, 32'h0FF0_FFFF, 12'd0, 0, 4'd12, 2'd0, 1, 5'd4); settle;
        expect_out("R9", wb_data, 32'd0);

        drive(32'd0, 32'd0, 12'd0, 0, 4'd0, 2'd1, 1, 5'd9); up = 20'hABCDE; settle;
        expect_out("R3", wb_data, 32'hABCD_E000);
        drive(32'd0, 32'd0, 12'd0, 0, 4'd0, 2'd2, 1, 5'd9); sw = 16'hBEEF; settle;
        expect_out("R3", wb_data, 32'h0000_BEEF);
        drive(32'd77, 32'd1, 12'd0, 0, 4'd0, 2'd3, 1, 5'd9); settle;
        expect_out("R3", wb_data, 32'd0);

        drive(32'd1, 32'd1, 12'd0, 0, 4'd0, 2'd0, 1, 5'd0); settle;
        expect_out("R5", 32'(wb_we), 32'd0);
        drive(32'd1, 32'd1, 12'd0, 0, 4'd0, 2'd0, 0, 5'd6); settle;
        expect_out("R8", 32'(wb_we), 32'd0);

        drive(32'h1234_CAFE, 32'd0, 12'd0, 0, 4'd0, 2'd0, 0, 5'd1); gwe = 1; settle;
        expect_out("R6", 32'(gpio_out), 32'h0000_CAFE);
        drive(32'h0000_5555, 32'd0, 12'd0, 0, 4'd0, 2'd0, 0, 5'd1); settle;
        expect_out("R6", 32'(gpio_out), 32'h0000_CAFE);

        drive(32'd3, 32'd4, 12'd0, 0, 4'd0, 2'd0, 1, 5'd2); gwe = 1; rst = 1; settle;
        expect_out("R7", {wb_we, wb_rd, gpio_out}, 32'd0);
        rst = 0;

        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            rs1 = $urandom; rs2 = $urandom; imm = 12'($urandom); up = 20'($urandom);
            sw = GW'($urandom); use_imm = 1'($urandom); op = 4'($urandom % 11);
            sel = 2'($urandom); rwe = 1'($urandom); gwe = 1'($urandom % 4 == 0);
            rd = 5'($urandom % 8);
        end
        settle;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule